// File: doc/BRIEF.md
# Operate-Group Micro-Operation Unit

This block executes the operate group of a 16-bit accumulator machine. An operate word carries no address. Six low bits each switch on one small operation on the accumulator and the one-bit link, and any mix of them may appear in the same word. The operations are ordered in three phases. The first phase clears. The second phase complements. The third phase increments the accumulator and then merges in the front-panel switch register. A carry out of the increment flips the link. The same word is also a halt when its top bit is clear. In that case the selected operations are still applied, and a one-cycle halt pulse tells the core to drop its run flag.

The core presents the instruction word, the current accumulator, the link and the switch value, and raises `issue` for one cycle. When the word belongs to the operate group, the new accumulator and link appear on registered outputs one clock later, with `done` marking them. A word outside the group leaves the outputs unchanged.

Top module: `opr_unit`

## Requirements
- R1: A word is in the operate group only when bits 14 through 6 are all zero. An issued word with any of those bits set is ignored: `done` and `halt` stay low and `acc_out`/`lnk_out` keep their previous values.
- R2: For an issued operate word, `done` is high for exactly the next cycle, and `acc_out`/`lnk_out` then carry the result. With `issue` low, `done` is low.
- R3: First phase: bit 0 clears the accumulator and bit 3 clears the link.
- R4: Second phase, acting on the first phase result: bit 1 inverts every accumulator bit and bit 4 inverts the link.
- R5: Third phase, acting on the second phase result: bit 2 adds one to the accumulator modulo 2^16, and a carry out of bit 15 inverts the link.
- R6: Within the third phase, bit 5 ORs `switches` into the accumulator after the increment.
- R7: When bit 15 of an operate word is clear, `halt` is high for the single cycle in which `done` is high, and the selected micro-operations are still applied. When bit 15 is set, `halt` stays low.
- R8: After reset, `done`, `halt`, `acc_out` and `lnk_out` are all zero.
- R9: Octal 0100003 yields all ones. Octal 0100006 yields the two's complement of the accumulator. Octal 0100041 yields the switch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Instruction word |
| acc_in | input | 16 | Current accumulator |
| lnk_in | input | 1 | Current link |
| switches | input | 16 | Data-switch register value |
| done | output | 1 | Result valid on acc_out/lnk_out |
| acc_out | output | 16 | New accumulator |
| lnk_out | output | 1 | New link |
| halt | output | 1 | One-cycle halt request |

## Verification
Phase order is the main target. A design that ORs in the switches before incrementing gives 0x1000 instead of 0x0F00 for accumulator 0x00FF with switches 0x0F00. A design that complements before clearing returns zero for octal 0100003 instead of all ones. The carry into the link is checked on a wrap from 0xFFFF, including the case where a complemented zero wraps and clears a set link. A design that ignores the carry leaves the link wrong. Halt words are exercised with and without operations to catch a halt that skips the operations or lasts too long. A non-operate word checks that a loose decode does not overwrite the held result. All 64 combinations of the operation bits are compared against an independent model in the bench.

// File: rtl/opr_pkg.sv
package opr_pkg;
  // Instruction bit positions; these are the encoding the core relies on.
  localparam int B_CLR_ACC = 0;
  localparam int B_CPL_ACC = 1;
  localparam int B_INC_ACC = 2;
  localparam int B_CLR_LNK = 3;
  localparam int B_CPL_LNK = 4;
  localparam int B_OR_SW   = 5;
  localparam int B_SEL_LO  = 6;
  localparam int B_SEL_HI  = 14;
  localparam int B_RUN     = 15;
  localparam int INSTR_W   = 16;

  typedef struct packed {
    logic clr_acc;
    logic clr_lnk;
    logic cpl_acc;
    logic cpl_lnk;
    logic inc_acc;
    logic or_sw;
    logic stop;
  } opr_ctl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               sel,
  output opr_ctl_t           ctl
);
  always_comb begin
    sel         = (instr[B_SEL_HI:B_SEL_LO] == '0);
    ctl.clr_acc = instr[B_CLR_ACC];
    ctl.clr_lnk = instr[B_CLR_LNK];
    ctl.cpl_acc = instr[B_CPL_ACC];
    ctl.cpl_lnk = instr[B_CPL_LNK];
    ctl.inc_acc = instr[B_INC_ACC];
    ctl.or_sw   = instr[B_OR_SW];
    ctl.stop    = ~instr[B_RUN];
  end
endmodule

// File: rtl/opr_phase.sv
module opr_phase
  import opr_pkg::*;
#(
  parameter int W     = 16,
  parameter int STAGE = 1
) (
  input  opr_ctl_t     ctl,
  input  logic [W-1:0] acc_i,
  input  logic         lnk_i,
  input  logic [W-1:0] sw,
  output logic [W-1:0] acc_o,
  output logic         lnk_o,
  output logic         carry
);
  function automatic logic [W:0] incr(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  generate
    if (STAGE == 1) begin : g_clear
      always_comb begin
        acc_o = ctl.clr_acc ? '0 : acc_i;
        lnk_o = ctl.clr_lnk ? 1'b0 : lnk_i;
        carry = 1'b0;
      end
    end else if (STAGE == 2) begin : g_compl
      always_comb begin
        acc_o = ctl.cpl_acc ? ~acc_i : acc_i;
        lnk_o = ctl.cpl_lnk ? ~lnk_i : lnk_i;
        carry = 1'b0;
      end
    end else begin : g_incr
      logic [W:0] sum;
      always_comb begin
        sum   = incr(acc_i);
        carry = ctl.inc_acc & sum[W];
        acc_o = (ctl.inc_acc ? sum[W-1:0] : acc_i) | (ctl.or_sw ? sw : '0);
        lnk_o = lnk_i ^ carry;
      end
    end
  endgenerate
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [INSTR_W-1:0] instr,
  input  logic [W-1:0]       acc_in,
  input  logic               lnk_in,
  input  logic [W-1:0]       switches,
  output logic               done,
  output logic [W-1:0]       acc_out,
  output logic               lnk_out,
  output logic               halt
);
  localparam int NPH = 3;

  logic     sel;
  opr_ctl_t ctl;
  logic [W-1:0] acc_s [NPH+1];
  logic         lnk_s [NPH+1];
  logic [NPH-1:0] carry_v;
  logic           inc_carry;
  logic           accept;

  opr_decode u_dec (.instr(instr), .sel(sel), .ctl(ctl));

  assign acc_s[0] = acc_in;
  assign lnk_s[0] = lnk_in;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    opr_phase #(.W(W), .STAGE(g + 1)) u_ph (
      .ctl  (ctl),
      .acc_i(acc_s[g]),
      .lnk_i(lnk_s[g]),
      .sw   (switches),
      .acc_o(acc_s[g+1]),
      .lnk_o(lnk_s[g+1]),
      .carry(carry_v[g])
    );
  end

  assign inc_carry = |carry_v;
  assign accept    = issue & sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      halt    <= 1'b0;
      acc_out <= '0;
      lnk_out <= 1'b0;
    end else begin
      done <= accept;
      halt <= accept & ctl.stop;
      if (accept) begin
        acc_out <= acc_s[NPH];
        lnk_out <= lnk_s[NPH];
      end
    end
  end
endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [15:0]  instr,
  input logic [W-1:0] acc_in,
  input logic         lnk_in,
  input logic [W-1:0] switches,
  input logic         done,
  input logic [W-1:0] acc_out,
  input logic         lnk_out,
  input logic         halt,
  input logic         sel,
  input logic         inc_carry
);
  a_r1_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[14:6] != '0) |=> (!done && !halt && $stable(acc_out) && $stable(lnk_out)));
  a_r2_done: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sel) |=> done);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !done);
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sel && instr[5:0] == 6'o04 && acc_in == '1)
      |=> (acc_out == '0 && lnk_out != $past(lnk_in)));
  a_r5_carry_src: assert property (@(posedge clk) disable iff (!rst_n)
    inc_carry |-> instr[2]);
  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sel && !instr[15]) |=> halt);
  a_r7_within: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> done);
  a_r9_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sel && instr[5:0] == 6'o03) |=> acc_out == '1);
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sel && instr[5:0] == 6'o41) |=> acc_out == $past(switches));
endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .acc_in(acc_in),
  .lnk_in(lnk_in), .switches(switches), .done(done), .acc_out(acc_out),
  .lnk_out(lnk_out), .halt(halt), .sel(sel), .inc_carry(inc_carry)
);

// File: tb/opr_unit_tb.sv
module opr_unit_tb;
  localparam int CLK_T = 10;
  localparam int NV = 9;

  localparam logic [15:0] V_INS [NV] = '{16'o100003, 16'o100006, 16'o100041,
    16'o100004, 16'o100006, 16'o000000, 16'o000011, 16'o100030, 16'o100044};
  localparam logic [15:0] V_AC  [NV] = '{16'h1234, 16'h0005, 16'h1234,
    16'hFFFF, 16'h0000, 16'h0055, 16'h7777, 16'h0001, 16'h00FF};
  localparam logic        V_L   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [15:0] V_DS  [NV] = '{16'h0000, 16'h0000, 16'hABCD,
    16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0F00};
  localparam logic [15:0] V_EAC [NV] = '{16'hFFFF, 16'hFFFB, 16'hABCD,
    16'h0000, 16'h0000, 16'h0055, 16'h0000, 16'h0001, 16'h0F00};
  localparam logic        V_EL  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        V_EH  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 0, rst_n = 0, issue = 0, lnk_in = 0;
  logic [15:0] instr = '0, acc_in = '0, switches = '0;
  logic done, lnk_out, halt;
  logic [15:0] acc_out;
  int total = 0, bad = 0;

  always #(CLK_T/2) clk = ~clk;

  opr_unit u_dut (.clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .acc_in(acc_in), .lnk_in(lnk_in), .switches(switches), .done(done),
    .acc_out(acc_out), .lnk_out(lnk_out), .halt(halt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model built from the requirement text.
  task automatic model(input logic [15:0] ins, input logic [15:0] a, input logic l,
                       input logic [15:0] ds, output logic [15:0] ra, output logic rl);
    logic [16:0] t;
    ra = a; rl = l;
    if (ins[0]) ra = 16'h0000;
    if (ins[3]) rl = 1'b0;
    if (ins[1]) ra = ra ^ 16'hFFFF;
    if (ins[4]) rl = ~rl;
    if (ins[2]) begin
      t = ra + 17'd1;
      ra = t[15:0];
      if (t[16]) rl = ~rl;
    end
    if (ins[5]) ra = ra | ds;
  endtask

  task automatic run(input logic [15:0] ins, input logic [15:0] a, input logic l,
                     input logic [15:0] ds);
    @(negedge clk);
    issue = 1; instr = ins; acc_in = a; lnk_in = l; switches = ds;
    @(negedge clk);
    issue = 0;
  endtask

  initial begin
    logic [15:0] ea;
    logic el;
    repeat (3) @(negedge clk);
    chk("R8 done", done, 0);
    chk("R8 halt", halt, 0);
    chk("R8 acc", acc_out, 0);
    chk("R8 lnk", lnk_out, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      run(V_INS[i], V_AC[i], V_L[i], V_DS[i]);
      chk($sformatf("R3/R4/R5/R6/R9 vec%0d acc", i), acc_out, V_EAC[i]);
      chk($sformatf("R3/R4/R5/R6/R9 vec%0d lnk", i), lnk_out, V_EL[i]);
      chk($sformatf("R7 vec%0d halt", i), halt, V_EH[i]);
      chk($sformatf("R2 vec%0d done", i), done, 1);
    end

    // R7: halt lasts one cycle, R2: done drops
    run(16'o000000, 16'h0001, 1'b0, 16'h0);
    @(negedge clk);
    chk("R7 halt single cycle", halt, 0);
    chk("R2 done single cycle", done, 0);

    // R1: non-operate words leave outputs untouched
    run(16'o100001, 16'h4321, 1'b1, 16'h0);
    chk("R1 setup acc", acc_out, 16'h0000);
    run(16'o001003, 16'hBEEF, 1'b0, 16'hFFFF);
    chk("R1 ignored done", done, 0);
    chk("R1 ignored halt", halt, 0);
    chk("R1 ignored acc", acc_out, 16'h0000);
    chk("R1 ignored lnk", lnk_out, 1);
    run(16'o000100, 16'hBEEF, 1'b0, 16'hFFFF);
    chk("R1 bit6 acc", acc_out, 16'h0000);
    chk("R1 bit6 done", done, 0);

    // All 64 operation mixes, both halt and run forms
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 64; k++) begin
        logic [15:0] w;
        w = {p[0] ? 1'b0 : 1'b1, 9'b0, k[5:0]};
        model(w, p[0] ? 16'hFFFF : 16'h8001, p[0], 16'h00F0, ea, el);
        run(w, p[0] ? 16'hFFFF : 16'h8001, p[0], 16'h00F0);
        chk($sformatf("R3/R4/R5/R6 mix%0d.%0d acc", p, k), acc_out, ea);
        chk($sformatf("R3/R4/R5/R6 mix%0d.%0d lnk", p, k), lnk_out, el);
        chk($sformatf("R7 mix%0d.%0d halt", p, k), halt, p[0]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_T * 5000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule